// File: doc/BRIEF.md
# USB Host Downstream Port Bus-State Controller

This block sequences the downstream port of a small USB host. It watches the sampled D+ and D- line levels to find a device being attached or removed. It drives bus-reset and resume signalling when firmware asks for them. While frames are enabled, it paces the start-of-frame strobe. Firmware drives it through single-cycle command strobes and reads level outputs and sticky interrupt flags. All timing is counted in ticks of a `tick` input. A tick is nominally one microsecond, so the default frame period of 1000 ticks is one millisecond.

Whenever frame generation is off, the port counts as suspended. A bus reset requested from that state does not just return to idle. After the reset it drives resume signalling, turns frame generation back on by itself and raises a wake-up flag, so frames follow the reset at once. Every bus reset ends with a one-cycle teardown pulse to each pipe. That pulse disables the pipe and releases its allocation.

Top module: `usb_host_port_ctl`

## Requirements
- R1: While `rst_n` is low, every output is 0 except `suspended`, which is 1.
- R2: A `vbus_on` strobe sets `vbus_req` and a `vbus_off` strobe clears it; set wins if both come together. While `vbus_req` is 0, `connected` is 0, no line detection runs and no connect or disconnect flag is raised.
- R3: With `vbus_req` high and no reset or resume signalling active, D+ or D- high on `DEBOUNCE_TICKS` consecutive ticks sets `connected` and raises `irq_conn`. A tick on which the lines match the current state restarts the count.
- R4: With `connected` high, both lines low on `DEBOUNCE_TICKS` consecutive ticks clears `connected` and raises `irq_disc`, with the same restart rule as R3.
- R5: A `bus_reset_cmd` strobe while the port is idle raises `drive_reset` in the next cycle and holds it for exactly `RESET_TICKS` ticks, after which it clears itself. Reset commands during reset or resume signalling are ignored.
- R6: In the cycle that bus reset signalling ends, `irq_rst` is raised and every bit of `pipe_kill` is 1 for exactly one cycle. At no other time is `pipe_kill` non-zero.
- R7: If `sof_en` was 0 when the reset was accepted, then the cycle the reset ends sets `sof_en`, raises `irq_wake` and starts `drive_resume` for `RESUME_TICKS` ticks. If `sof_en` was 1, there is no resume signalling and no wake flag.
- R8: While `sof_en` is 1 and neither reset nor resume is driven, `sof_strobe` pulses for one cycle after the first tick, and then after every `FRAME_TICKS`-th tick. The count restarts from the first tick whenever frames are re-enabled or signalling ends. No strobe appears during reset or resume.
- R9: `sof_on` and `sof_off` strobes set and clear `sof_en`, and `suspended` is always the inverse of `sof_en`.
- R10: Each interrupt flag stays set until a strobe on its own clear input; a set and a clear in the same cycle leave the flag set.
- R11: Line detection is frozen during reset and resume signalling, so lines held low by the reset do not cause a disconnect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe, nominally 1 us |
| line_dp | input | 1 | Sampled D+ level |
| line_dm | input | 1 | Sampled D- level |
| vbus_on | input | 1 | Strobe: request port power |
| vbus_off | input | 1 | Strobe: drop port power request |
| sof_on | input | 1 | Strobe: enable frame generation |
| sof_off | input | 1 | Strobe: disable frame generation |
| bus_reset_cmd | input | 1 | Strobe: start a bus reset |
| clr_conn | input | 1 | Strobe: clear `irq_conn` |
| clr_disc | input | 1 | Strobe: clear `irq_disc` |
| clr_rst | input | 1 | Strobe: clear `irq_rst` |
| clr_wake | input | 1 | Strobe: clear `irq_wake` |
| vbus_req | output | 1 | Port power request |
| connected | output | 1 | Debounced device presence |
| sof_en | output | 1 | Frame generation enabled |
| suspended | output | 1 | Port suspended (frames off) |
| drive_reset | output | 1 | Request to drive bus reset on the lines |
| drive_resume | output | 1 | Request to drive resume on the lines |
| sof_strobe | output | 1 | One-cycle start-of-frame request |
| pipe_kill | output | N_PIPES | One-cycle disable/de-allocate pulse per pipe |
| irq_conn | output | 1 | Sticky connect flag |
| irq_disc | output | 1 | Sticky disconnect flag |
| irq_rst | output | 1 | Sticky reset-sent flag |
| irq_wake | output | 1 | Sticky host wake-up flag |

## Verification
The bench uses `RESET_TICKS=4`, `RESUME_TICKS=3`, `DEBOUNCE_TICKS=3`, `FRAME_TICKS=5` and `N_PIPES=4`. With these values a whole reset-from-suspend sequence, several frame periods and every debounce restart case fit in a few hundred cycles. The short debounce window is also shorter than the reset. If the freeze were missing, the low lines during reset would produce a disconnect, so the test would catch it. The five-tick frame makes the restart of the frame count after re-enable and after reset visible against a count that would otherwise be part-way through.

// File: rtl/usb_host_port_ctl.sv
module usb_host_port_ctl #(
  parameter int RESET_TICKS    = 10000,
  parameter int RESUME_TICKS   = 20000,
  parameter int DEBOUNCE_TICKS = 100,
  parameter int FRAME_TICKS    = 1000,
  parameter int N_PIPES        = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               line_dp,
  input  logic               line_dm,
  input  logic               vbus_on,
  input  logic               vbus_off,
  input  logic               sof_on,
  input  logic               sof_off,
  input  logic               bus_reset_cmd,
  input  logic               clr_conn,
  input  logic               clr_disc,
  input  logic               clr_rst,
  input  logic               clr_wake,
  output logic               vbus_req,
  output logic               connected,
  output logic               sof_en,
  output logic               suspended,
  output logic               drive_reset,
  output logic               drive_resume,
  output logic               sof_strobe,
  output logic [N_PIPES-1:0] pipe_kill,
  output logic               irq_conn,
  output logic               irq_disc,
  output logic               irq_rst,
  output logic               irq_wake
);

  localparam int TMAX = (RESET_TICKS > RESUME_TICKS) ? RESET_TICKS : RESUME_TICKS;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int DW   = $clog2(DEBOUNCE_TICKS + 1);
  localparam int FW   = $clog2(FRAME_TICKS + 1);
  localparam logic [TW-1:0] RST_LAST = TW'(RESET_TICKS - 1);
  localparam logic [TW-1:0] RSM_LAST = TW'(RESUME_TICKS - 1);
  localparam logic [DW-1:0] DB_LAST  = DW'(DEBOUNCE_TICKS - 1);
  localparam logic [FW-1:0] FR_LAST  = FW'(FRAME_TICKS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RESET, ST_RESUME} bus_st_t;

  bus_st_t       st;
  logic [TW-1:0] tmr;
  logic          from_susp;
  logic [DW-1:0] db_cnt;
  logic [FW-1:0] fr_cnt;

  wire line_up  = line_dp | line_dm;
  wire idle     = (st == ST_IDLE);
  wire vbus_nxt = vbus_on | (vbus_req & ~vbus_off);
  wire rst_done = (st == ST_RESET)  && tick && (tmr == RST_LAST);
  wire rsm_done = (st == ST_RESUME) && tick && (tmr == RSM_LAST);
  wire db_look  = vbus_req && idle && tick;
  wire db_step  = db_look && (line_up != connected);
  wire db_hit   = db_step && (db_cnt == DB_LAST);
  wire ev_conn  = db_hit && line_up;
  wire ev_disc  = db_hit && !line_up;
  wire ev_wake  = rst_done && from_susp;
  wire fr_run   = sof_en && idle;

  assign suspended    = ~sof_en;
  assign drive_reset  = (st == ST_RESET);
  assign drive_resume = (st == ST_RESUME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      tmr       <= '0;
      from_susp <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (bus_reset_cmd) begin
          st        <= ST_RESET;
          tmr       <= '0;
          from_susp <= ~sof_en;
        end
        ST_RESET: if (rst_done) begin
          st  <= from_susp ? ST_RESUME : ST_IDLE;
          tmr <= '0;
        end else if (tick) tmr <= tmr + 1'b1;
        ST_RESUME: if (rsm_done) begin
          st  <= ST_IDLE;
          tmr <= '0;
        end else if (tick) tmr <= tmr + 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbus_req  <= 1'b0;
      connected <= 1'b0;
      db_cnt    <= '0;
    end else begin
      vbus_req <= vbus_nxt;
      if (!vbus_nxt) begin
        connected <= 1'b0;
        db_cnt    <= '0;
      end else if (db_hit) begin
        connected <= line_up;
        db_cnt    <= '0;
      end else if (db_step) begin
        db_cnt <= db_cnt + 1'b1;
      end else if (db_look) begin
        db_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sof_en     <= 1'b0;
      fr_cnt     <= '0;
      sof_strobe <= 1'b0;
      pipe_kill  <= '0;
    end else begin
      if (ev_wake || sof_on) sof_en <= 1'b1;
      else if (sof_off)      sof_en <= 1'b0;
      if (!fr_run)   fr_cnt <= '0;
      else if (tick) fr_cnt <= (fr_cnt == FR_LAST) ? '0 : fr_cnt + 1'b1;
      sof_strobe <= fr_run && tick && (fr_cnt == '0);
      pipe_kill  <= {N_PIPES{rst_done}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_conn <= 1'b0;
      irq_disc <= 1'b0;
      irq_rst  <= 1'b0;
      irq_wake <= 1'b0;
    end else begin
      irq_conn <= ev_conn  | (irq_conn & ~clr_conn);
      irq_disc <= ev_disc  | (irq_disc & ~clr_disc);
      irq_rst  <= rst_done | (irq_rst  & ~clr_rst);
      irq_wake <= ev_wake  | (irq_wake & ~clr_wake);
    end
  end

endmodule

// File: rtl/usb_host_port_ctl_chk.sv
module usb_host_port_ctl_chk #(
  parameter int N_PIPES = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vbus_req,
  input logic               connected,
  input logic               sof_en,
  input logic               drive_reset,
  input logic               drive_resume,
  input logic               sof_strobe,
  input logic [N_PIPES-1:0] pipe_kill,
  input logic               irq_conn,
  input logic               irq_rst,
  input logic               irq_wake,
  input logic               clr_conn
);

  p_conn_needs_vbus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    connected |-> vbus_req);

  p_kill_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|pipe_kill) |=> (pipe_kill == '0));

  p_kill_at_reset_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|pipe_kill) |-> ($fell(drive_reset) && irq_rst && (&pipe_kill)));

  p_wake_resumes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_wake) |-> (sof_en && drive_resume));

  p_drive_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_reset && drive_resume));

  p_sof_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sof_strobe |-> ($past(sof_en) && !$past(drive_reset) && !$past(drive_resume)));

  p_sof_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sof_strobe |=> !sof_strobe);

  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_conn && !clr_conn) |=> irq_conn);

endmodule

bind usb_host_port_ctl usb_host_port_ctl_chk #(.N_PIPES(N_PIPES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .vbus_req     (vbus_req),
  .connected    (connected),
  .sof_en       (sof_en),
  .drive_reset  (drive_reset),
  .drive_resume (drive_resume),
  .sof_strobe   (sof_strobe),
  .pipe_kill    (pipe_kill),
  .irq_conn     (irq_conn),
  .irq_rst      (irq_rst),
  .irq_wake     (irq_wake),
  .clr_conn     (clr_conn)
);

// File: tb/usb_host_port_ctl_bench.sv
module usb_host_port_ctl_bench;
  localparam int NP = 4;
  localparam int C_VON = 0, C_VOFF = 1, C_SON = 2, C_SOFF = 3, C_RST = 4;
  localparam int C_CCONN = 5, C_CDISC = 6, C_CRST = 7, C_CWAKE = 8;

  logic clk = 0, rst_n = 0, tick = 0, dp = 0, dm = 0;
  logic [8:0] cmd = '0;
  logic vbus_req, connected, sof_en, suspended, drive_reset, drive_resume, sof_strobe;
  logic [NP-1:0] pipe_kill;
  logic irq_conn, irq_disc, irq_rst, irq_wake;

  int checks = 0, errors = 0;
  bit fin = 0;
  byte q[$];
  logic p_conn = 0, p_disc = 0, p_rst = 0, p_wake = 0;

  always #10 clk = ~clk;

  usb_host_port_ctl #(.RESET_TICKS(4), .RESUME_TICKS(3), .DEBOUNCE_TICKS(3),
                      .FRAME_TICKS(5), .N_PIPES(NP)) u_usb_host_port_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_dp(dp), .line_dm(dm),
    .vbus_on(cmd[C_VON]), .vbus_off(cmd[C_VOFF]), .sof_on(cmd[C_SON]),
    .sof_off(cmd[C_SOFF]), .bus_reset_cmd(cmd[C_RST]), .clr_conn(cmd[C_CCONN]),
    .clr_disc(cmd[C_CDISC]), .clr_rst(cmd[C_CRST]), .clr_wake(cmd[C_CWAKE]),
    .vbus_req(vbus_req), .connected(connected), .sof_en(sof_en), .suspended(suspended),
    .drive_reset(drive_reset), .drive_resume(drive_resume), .sof_strobe(sof_strobe),
    .pipe_kill(pipe_kill), .irq_conn(irq_conn), .irq_disc(irq_disc),
    .irq_rst(irq_rst), .irq_wake(irq_wake));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag(input byte e);
    case (e)
      "S": return "R8";
      "K": return "R6";
      "R": return "R6";
      "W": return "R7";
      "C": return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic see(input byte e);
    byte x;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL %s: unexpected event %c, expected none", tag(e), e);
    end else begin
      x = q.pop_front();
      if (x != e) begin
        errors++;
        $display("FAIL %s: event %c, expected %c", tag(x), e, x);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      if (|pipe_kill)               see("K");
      if (irq_rst && !p_rst)        see("R");
      if (irq_wake && !p_wake)      see("W");
      if (sof_strobe)               see("S");
      if (irq_conn && !p_conn)      see("C");
      if (irq_disc && !p_disc)      see("D");
      p_conn = irq_conn; p_disc = irq_disc; p_rst = irq_rst; p_wake = irq_wake;
    end
  end

  task automatic tk(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic fw(input int b);
    @(negedge clk); cmd[b] = 1;
    @(negedge clk); cmd[b] = 0;
  endtask

  task automatic fw_tick(input int b);
    @(negedge clk); cmd[b] = 1; tick = 1;
    @(negedge clk); cmd[b] = 0; tick = 0;
  endtask

  task automatic finish_run;
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 vbus_req", vbus_req, 0);
    chk("R1 connected", connected, 0);
    chk("R1 sof_en", sof_en, 0);
    chk("R1 suspended", suspended, 1);
    chk("R1 drives", {drive_reset, drive_resume, sof_strobe}, 0);
    chk("R1 irqs", {irq_conn, irq_disc, irq_rst, irq_wake}, 0);
    chk("R1 pipe_kill", pipe_kill, 0);

    // R2 no detection without power request
    dp = 1;
    tk(5);
    chk("R2 connected w/o vbus", connected, 0);
    chk("R2 irq_conn w/o vbus", irq_conn, 0);
    fw(C_VON);
    chk("R2 vbus_req set", vbus_req, 1);

    // R3 connect on D+
    q.push_back("C");
    tk(2);
    chk("R3 not yet connected", connected, 0);
    tk(1);
    chk("R3 connected", connected, 1);
    chk("R3 irq_conn", irq_conn, 1);
    fw(C_CCONN);
    chk("R10 irq_conn cleared", irq_conn, 0);

    // R5/R6/R7/R11 reset from suspend
    fw(C_RST);
    chk("R5 drive_reset on", drive_reset, 1);
    dp = 0;
    tk(3);
    chk("R5 drive_reset held", drive_reset, 1);
    chk("R11 no disconnect during reset", connected, 1);
    q.push_back("K"); q.push_back("R"); q.push_back("W");
    tk(1);
    dp = 1;
    chk("R5 drive_reset done", drive_reset, 0);
    chk("R6 pipe_kill all", pipe_kill, 4'hF);
    chk("R6 irq_rst", irq_rst, 1);
    chk("R7 drive_resume", drive_resume, 1);
    chk("R7 sof_en by hw", sof_en, 1);
    chk("R9 not suspended", suspended, 0);
    chk("R7 irq_wake", irq_wake, 1);
    @(negedge clk);
    chk("R6 pipe_kill single", pipe_kill, 0);
    tk(2);
    chk("R7 resume held", drive_resume, 1);
    tk(1);
    chk("R7 resume done", drive_resume, 0);
    chk("R8 no sof in resume", sof_strobe, 0);
    chk("R11 connected after resume", connected, 1);

    // R8 frames right after resume, period 5
    q.push_back("S"); q.push_back("S");
    tk(1);
    chk("R8 first sof", sof_strobe, 1);
    tk(4);
    chk("R8 mid frame", sof_strobe, 0);
    tk(1);
    chk("R8 second sof", sof_strobe, 1);

    fw(C_CRST); fw(C_CWAKE);
    chk("R10 irq_rst cleared", irq_rst, 0);
    chk("R10 irq_wake cleared", irq_wake, 0);

    // R5 ignore nested command; R10 set over clear; R7 no resume when running
    fw(C_RST);
    chk("R5 second reset on", drive_reset, 1);
    tk(2);
    fw(C_RST);
    q.push_back("K"); q.push_back("R");
    tk(1);
    fw_tick(C_CRST);
    chk("R5 nested cmd ignored", drive_reset, 0);
    chk("R10 set wins over clear", irq_rst, 1);
    chk("R7 no resume when running", drive_resume, 0);
    chk("R7 no wake when running", irq_wake, 0);
    q.push_back("S");
    tk(1);
    chk("R8 sof restarts after reset", sof_strobe, 1);

    // R9 suspend via firmware, R8 restart on enable
    fw(C_SOFF);
    chk("R9 suspended", suspended, 1);
    chk("R9 sof_en off", sof_en, 0);
    tk(6);
    chk("R8 no sof suspended", sof_strobe, 0);
    fw(C_SON);
    chk("R9 resumed", suspended, 0);
    q.push_back("S");
    tk(1);
    chk("R8 sof on re-enable", sof_strobe, 1);
    fw(C_SOFF);

    // R4 disconnect with glitch restart
    dp = 0; dm = 0;
    tk(2);
    dp = 1;
    tk(1);
    dp = 0;
    tk(2);
    chk("R4 glitch restarts count", connected, 1);
    q.push_back("D");
    tk(1);
    chk("R4 disconnected", connected, 0);
    chk("R4 irq_disc", irq_disc, 1);

    // R3 connect on D- with glitch restart
    dm = 1;
    tk(2);
    dm = 0;
    tk(1);
    dm = 1;
    tk(2);
    chk("R3 glitch restarts count", connected, 0);
    q.push_back("C");
    tk(1);
    chk("R3 connected on D-", connected, 1);

    // R2 power drop forces disconnect, no flag
    fw(C_VOFF);
    chk("R2 vbus_req cleared", vbus_req, 0);
    chk("R2 connected dropped", connected, 0);
    tk(4);
    chk("R2 stays disconnected", connected, 0);
    chk("R2 no new disc flag", irq_disc, 1);

    @(negedge clk);
    chk("R8 all expected events seen", q.size(), 0);
    finish_run();
  end
endmodule